// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block decides when a processor core may stop its clocks and how it comes back. Software requests a low-power state with either a wait-for-interrupt or a wait-for-event strobe. A one-bit event latch, set by a peer processor's send-event pulse, by an external event line or by any interrupt wake-up, lets a wait-for-event request fall straight through instead of sleeping. When that happens the request consumes the latch.

A deep-sleep select input picks the depth. Light sleep stops only the core clock, so peripherals on the system clock keep running. Deep sleep also turns off the system clock, the PLL and the flash. An interrupt ends either state. Waking from deep sleep brings the resources back one at a time: the PLL first, held for a lock count, then the flash, held for a ready count, then the system clock, and only after that the core clock. The first cycle of normal execution after any wake carries a one-cycle restore strobe, which tells software to run its restore tasks.

With the sleep-on-exit input set, a return-from-handler strobe puts the core back to sleep at the selected depth. Firmware that does all its work in interrupt handlers can therefore sleep without a main loop.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, the status is RUN (0), all four clock and power enables are 1, the event flag is 0 and the restore strobe is 0.
- R2: In RUN, a wait-for-interrupt request with no pending interrupt enters light sleep (status 1) on the next cycle when deep select is 0, or deep sleep (status 2) when it is 1. If an interrupt is already pending, the block stays in RUN with every enable at 1. A wait-for-interrupt request takes priority over a wait-for-event request in the same cycle.
- R3: In RUN, a wait-for-event request with the event flag at 0 enters sleep at the selected depth. With the flag at 1, it clears the flag on the next cycle and the block stays in RUN.
- R4: A send-event or external-event pulse sets the event flag on the next cycle in any state. The flag stays at 1 until a wait-for-event request consumes it. A set in the same cycle as a consuming request wins, so the flag stays at 1.
- R5: In light sleep (status 1), the core clock enable is 0 while the system clock, PLL and flash enables stay at 1.
- R6: In deep sleep (status 2), the core clock, system clock, PLL and flash enables are all 0.
- R7: A pending interrupt in light sleep returns the block to RUN on the next cycle. Any interrupt wake-up sets the event flag. The restore strobe is 1 for exactly the first RUN cycle after a wake.
- R8: A pending interrupt in deep sleep starts the wake sequence:
  - status 3 for PLL_LOCK_CYC cycles, with only the PLL enabled;
  - then status 4 for FLASH_RDY_CYC cycles, with the PLL and flash enabled;
  - then status 5 for one cycle, with the system clock added;
  - then RUN, with the core clock enabled and the restore strobe raised.
- R9: In RUN, a return-from-handler strobe with sleep-on-exit at 1 and no pending interrupt enters sleep at the depth given by deep select. With sleep-on-exit at 0, or with an interrupt pending, the block stays in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| wfe_req | input | 1 | Wait-for-event request strobe |
| sev_in | input | 1 | Send-event pulse from a peer processor |
| ext_evt | input | 1 | External event pulse |
| irq_pend | input | 1 | An enabled interrupt is pending |
| hdl_ret | input | 1 | Return-from-handler strobe |
| deep_sel | input | 1 | Sleep depth select: 0 light, 1 deep |
| sleep_on_exit | input | 1 | Re-enter sleep on handler return |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| pll_en | output | 1 | PLL enable |
| flash_en | output | 1 | Flash enable |
| pwr_state | output | 3 | Status: 0 RUN, 1 light sleep, 2 deep sleep, 3 PLL wait, 4 flash wait, 5 system clock step |
| ev_flag | output | 1 | Event latch |
| restore_pulse | output | 1 | One-cycle strobe on the first RUN cycle after a wake |

## Verification
The bench goes after these corner cases:
- **Wait-for-event with the event flag set.** A design that ignored the flag would sleep there.
- **A set pulse in the same cycle as a consuming request.** A design that put the clear first would lose the event.
- **Wait-for-interrupt with an interrupt already pending.** A design that missed the pending check would gate the core clock for a cycle.
- **The deep wake ramp, counted cycle by cycle.** A counter off by one, or an order that raised the core clock early, would show up as the wrong status in a specific cycle.
- **Handler return under both sleep-on-exit settings.** A design that ignored the bit would either sleep on every return or never sleep.
- **Length of the restore strobe.** A strobe held too long or missing on a deep wake is caught.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int PLL_LOCK_CYC  = 4,
  parameter int FLASH_RDY_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_req,
  input  logic       wfe_req,
  input  logic       sev_in,
  input  logic       ext_evt,
  input  logic       irq_pend,
  input  logic       hdl_ret,
  input  logic       deep_sel,
  input  logic       sleep_on_exit,
  output logic       core_clk_en,
  output logic       sys_clk_en,
  output logic       pll_en,
  output logic       flash_en,
  output logic [2:0] pwr_state,
  output logic       ev_flag,
  output logic       restore_pulse
);
  localparam int CMAX = (PLL_LOCK_CYC > FLASH_RDY_CYC) ? PLL_LOCK_CYC : FLASH_RDY_CYC;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX + 1) : 1;
  localparam logic [CW-1:0] PLL_LAST = CW'(PLL_LOCK_CYC - 1);
  localparam logic [CW-1:0] FL_LAST  = CW'(FLASH_RDY_CYC - 1);

  typedef enum logic [2:0] {
    S_RUN  = 3'd0,
    S_SLP  = 3'd1,
    S_DSLP = 3'd2,
    S_WPLL = 3'd3,
    S_WFL  = 3'd4,
    S_WSYS = 3'd5
  } st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt;
  logic          ev_q, was_run;
  logic          go_sleep, wake, wfe_only;

  assign wfe_only = ~wfi_req & wfe_req;
  assign go_sleep = (wfi_req & ~irq_pend)
                  | (wfe_only & ~ev_q)
                  | (~wfi_req & ~wfe_req & hdl_ret & sleep_on_exit & ~irq_pend);
  assign wake     = ((st == S_SLP) | (st == S_DSLP)) & irq_pend;

  always_comb begin
    nxt = st;
    case (st)
      S_RUN:   if (go_sleep) nxt = deep_sel ? S_DSLP : S_SLP;
      S_SLP:   if (irq_pend) nxt = S_RUN;
      S_DSLP:  if (irq_pend) nxt = S_WPLL;
      S_WPLL:  if (cnt == PLL_LAST) nxt = S_WFL;
      S_WFL:   if (cnt == FL_LAST) nxt = S_WSYS;
      S_WSYS:  nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= '0;
      ev_q    <= 1'b0;
      was_run <= 1'b1;
    end else begin
      st      <= nxt;
      was_run <= (st == S_RUN);
      if ((st == S_WPLL || st == S_WFL) && nxt == st)
        cnt <= cnt + 1'b1;
      else
        cnt <= '0;
      if (sev_in | ext_evt | wake)
        ev_q <= 1'b1;
      else if ((st == S_RUN) & wfe_only & ev_q)
        ev_q <= 1'b0;
    end
  end

  assign core_clk_en   = (st == S_RUN);
  assign sys_clk_en    = (st == S_RUN) | (st == S_SLP) | (st == S_WSYS);
  assign pll_en        = (st != S_DSLP);
  assign flash_en      = (st != S_DSLP) & (st != S_WPLL);
  assign pwr_state     = st;
  assign ev_flag       = ev_q;
  assign restore_pulse = (st == S_RUN) & ~was_run;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wfi_req,
  input logic       wfe_req,
  input logic       sev_in,
  input logic       ext_evt,
  input logic       irq_pend,
  input logic       core_clk_en,
  input logic       sys_clk_en,
  input logic       pll_en,
  input logic       flash_en,
  input logic [2:0] pwr_state,
  input logic       ev_flag,
  input logic       restore_pulse
);
  AST_WFI_PENDING_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && wfi_req && irq_pend) |=> (pwr_state == 3'd0)); // R2
  AST_WFE_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && wfe_req && !wfi_req && ev_flag && !sev_in && !ext_evt)
      |=> (pwr_state == 3'd0 && !ev_flag)); // R3
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (sev_in || ext_evt) |=> ev_flag); // R4
  AST_LIGHT_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd1) |-> (!core_clk_en && sys_clk_en && pll_en && flash_en)); // R5
  AST_DEEP_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2) |-> (!core_clk_en && !sys_clk_en && !pll_en && !flash_en)); // R6
  AST_RESTORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |=> !restore_pulse); // R7
  AST_RESTORE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |-> core_clk_en); // R7
  AST_FLASH_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_en) |-> (pll_en && $past(pll_en))); // R8
  AST_CORE_AFTER_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(sys_clk_en)); // R8
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
  .sev_in(sev_in), .ext_evt(ext_evt), .irq_pend(irq_pend),
  .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .pll_en(pll_en),
  .flash_en(flash_en), .pwr_state(pwr_state), .ev_flag(ev_flag),
  .restore_pulse(restore_pulse)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int LOCK = 4;
  localparam int RDY  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, sev_in = 0, ext_evt = 0, irq_pend = 0;
  logic hdl_ret = 0, deep_sel = 0, sleep_on_exit = 0;
  logic core_clk_en, sys_clk_en, pll_en, flash_en, ev_flag, restore_pulse;
  logic [2:0] pwr_state;

  int checks = 0, failures = 0;
  logic exp_ev = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic [3:0] en;
    logic       ev;
    logic       rs;
    string      tag;
  } item_t;
  item_t q[$];
  item_t it;

  always #5 clk = ~clk;

  lpm_ctrl #(.PLL_LOCK_CYC(LOCK), .FLASH_RDY_CYC(RDY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_in(sev_in), .ext_evt(ext_evt), .irq_pend(irq_pend), .hdl_ret(hdl_ret),
    .deep_sel(deep_sel), .sleep_on_exit(sleep_on_exit),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .pll_en(pll_en),
    .flash_en(flash_en), .pwr_state(pwr_state), .ev_flag(ev_flag),
    .restore_pulse(restore_pulse)
  );

  // enables {core, sys, pll, flash} per status, from R1/R5/R6/R8
  function automatic logic [3:0] en_of(input logic [2:0] s);
    case (s)
      3'd0: return 4'b1111;
      3'd1: return 4'b0111;
      3'd2: return 4'b0000;
      3'd3: return 4'b0010;
      3'd4: return 4'b0011;
      3'd5: return 4'b0111;
      default: return 4'bxxxx;
    endcase
  endfunction

  task automatic tick(input logic [2:0] st, input logic rs, input string tag);
    item_t e;
    e.st = st; e.en = en_of(st); e.ev = exp_ev; e.rs = rs; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    wfi_req = 0; wfe_req = 0; sev_in = 0; ext_evt = 0; hdl_ret = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (pwr_state !== it.st || {core_clk_en, sys_clk_en, pll_en, flash_en} !== it.en ||
          ev_flag !== it.ev || restore_pulse !== it.rs) begin
        failures++;
        $display("FAIL %s actual st=%0d en=%b ev=%b rs=%b expected st=%0d en=%b ev=%b rs=%b",
                 it.tag, pwr_state, {core_clk_en, sys_clk_en, pll_en, flash_en}, ev_flag,
                 restore_pulse, it.st, it.en, it.ev, it.rs);
      end
    end
  end

  task automatic deep_wake_seq(input string tag);
    irq_pend = 1; exp_ev = 1;
    tick(3'd3, 0, tag);
    irq_pend = 0;
    for (int i = 1; i < LOCK; i++) tick(3'd3, 0, tag);
    for (int i = 0; i < RDY; i++) tick(3'd4, 0, tag);
    tick(3'd5, 0, tag);
    tick(3'd0, 1, tag);
    tick(3'd0, 0, tag);
  endtask

  task automatic light_wake(input string tag);
    irq_pend = 1; exp_ev = 1;
    tick(3'd0, 1, tag);
    irq_pend = 0;
    tick(3'd0, 0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (pwr_state !== 3'd0 || {core_clk_en, sys_clk_en, pll_en, flash_en} !== 4'b1111 ||
        ev_flag !== 1'b0 || restore_pulse !== 1'b0) begin
      failures++;
      $display("FAIL R1 actual st=%0d en=%b ev=%b rs=%b expected st=0 en=1111 ev=0 rs=0",
               pwr_state, {core_clk_en, sys_clk_en, pll_en, flash_en}, ev_flag, restore_pulse);
    end
    rst_n = 1;
    tick(3'd0, 0, "R1");

    // light sleep through WFI
    wfi_req = 1; tick(3'd1, 0, "R2");
    tick(3'd1, 0, "R5");
    sev_in = 1; exp_ev = 1; tick(3'd1, 0, "R4");
    light_wake("R7");

    // WFE with flag set falls through
    wfe_req = 1; exp_ev = 0; tick(3'd0, 0, "R3");
    // WFE with flag clear sleeps
    wfe_req = 1; tick(3'd1, 0, "R3");
    light_wake("R7");
    wfe_req = 1; exp_ev = 0; tick(3'd0, 0, "R3");

    // event latching and set-wins rule
    sev_in = 1; exp_ev = 1; tick(3'd0, 0, "R4");
    tick(3'd0, 0, "R4");
    ext_evt = 1; wfe_req = 1; tick(3'd0, 0, "R4");
    wfe_req = 1; exp_ev = 0; tick(3'd0, 0, "R4");
    ext_evt = 1; exp_ev = 1; tick(3'd0, 0, "R4");
    wfe_req = 1; exp_ev = 0; tick(3'd0, 0, "R3");

    // WFI with pending interrupt falls through; WFI wins over WFE
    wfi_req = 1; irq_pend = 1; tick(3'd0, 0, "R2");
    irq_pend = 0;
    sev_in = 1; exp_ev = 1; tick(3'd0, 0, "R4");
    wfi_req = 1; wfe_req = 1; tick(3'd1, 0, "R2");
    light_wake("R7");

    // deep sleep through WFI
    deep_sel = 1;
    wfi_req = 1; tick(3'd2, 0, "R2");
    tick(3'd2, 0, "R6");
    tick(3'd2, 0, "R6");
    deep_wake_seq("R8");

    // deep sleep through WFE
    wfe_req = 1; exp_ev = 0; tick(3'd0, 0, "R3");
    wfe_req = 1; tick(3'd2, 0, "R3");
    deep_wake_seq("R8");

    // sleep-on-exit
    deep_sel = 0; sleep_on_exit = 0;
    hdl_ret = 1; tick(3'd0, 0, "R9");
    sleep_on_exit = 1;
    hdl_ret = 1; irq_pend = 1; tick(3'd0, 0, "R9");
    irq_pend = 0;
    hdl_ret = 1; tick(3'd1, 0, "R9");
    light_wake("R9");
    deep_sel = 1;
    hdl_ret = 1; tick(3'd2, 0, "R9");
    deep_wake_seq("R9");
    tick(3'd0, 0, "R9");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule